// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is the shift and rotate execution unit of a small processor core. Each accepted request holds a data word, a shift amount, an operation code and the current carry flag. One clock edge later the unit gives the shifted word, the new carry flag, and zero and negative flags for the shifted word. The carry flag takes part in every operation. For shifts and plain rotates it receives the last bit that left the word. For the through-carry rotates it is one more position in a ring of WIDTH+1 bits.

A shift by n always gives exactly the same word and carry as n one-bit steps of the same kind applied in a row. The datapath meets this by chaining power-of-two stages, where each stage is itself an exact multi-step move. An amount of zero leaves the word and the carry as they were.

Top module: `shift_rotate_unit`

## Requirements
- R1: A request taken with `inValid` high produces its results, with `outValid` high, on the clock edge that captures it. When `inValid` is low, `outValid` goes low and `result` and `carryOut` hold their values.
- R2: Operation code 3'd0 shifts left and fills with zeros. The carry takes the last bit that left bit WIDTH-1, which is `operand[WIDTH-n]`.
- R3: Operation code 3'd1 shifts right and fills with zeros. The carry takes `operand[n-1]`.
- R4: Operation code 3'd2 shifts right and fills with copies of the original sign bit. The carry takes `operand[n-1]`. Read as two's complement, the result equals the operand divided by 2^n, rounded toward minus infinity.
- R5: Operation code 3'd3 rotates left without the carry. Each bit that leaves the top enters bit 0, and the carry ends equal to result bit 0.
- R6: Operation code 3'd4 rotates right without the carry. The carry ends equal to result bit WIDTH-1.
- R7: Operation code 3'd5 rotates left through the carry. The ring is {carry, word}, WIDTH+1 bits: the old carry enters bit 0 and the bit that leaves the top becomes the new carry.
- R8: Operation code 3'd6 rotates right through the carry. The old carry enters bit WIDTH-1 and the bit that leaves bit 0 becomes the new carry.
- R9: An amount of 0 returns the operand unchanged and `carryOut` equal to `carryIn`, for every operation code.
- R10: Operation code 3'd7 passes the operand and the carry through unchanged, whatever the amount.
- R11: `zeroFlag` is high exactly when the result is all zeros, and `negFlag` equals result bit WIDTH-1.
- R12: While reset is active, `outValid`, `result`, `carryOut`, `zeroFlag` and `negFlag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A request is present this cycle |
| opSel | input | 3 | Operation code |
| count | input | 5 | Shift amount (log2 WIDTH bits) |
| operand | input | 32 | Word to shift |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | Results below belong to a request |
| result | output | 32 | Shifted word |
| carryOut | output | 1 | New carry flag |
| zeroFlag | output | 1 | Result is all zeros |
| negFlag | output | 1 | Top bit of the result |

## Verification
Each output is a register fed straight from the combinational stage chain. The results of a request driven before a rising edge are due on that same edge. The bench drives every request on a falling edge and reads the outputs on the next falling edge, half a period after they settle. Hold behaviour is read one more falling edge later, after an idle cycle whose inputs have changed. Reset values are read while reset is still active.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROTL = 3'd3,
    OP_ROTR = 3'd4,
    OP_RCL  = 3'd5,
    OP_RCR  = 3'd6,
    OP_PASS = 3'd7
  } srOp_e;

  // What enters the vacated positions of a stage
  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2,
    FILL_RING = 2'd3
  } srFill_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    toLeft;
    srFill_e fill;
    logic    bypass;
  } srStrobe_t;

endpackage

// File: rtl/sru_ctrl.sv
module sru_ctrl
  import sru_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] opSel,
  output srStrobe_t  strobe,
  output logic       outValid
);

  always_comb begin
    strobe        = '0;
    strobe.load   = inValid;
    strobe.toLeft = 1'b0;
    strobe.fill   = FILL_ZERO;
    strobe.bypass = 1'b0;
    case (srOp_e'(opSel))
      OP_SHL:  begin strobe.toLeft = 1'b1; strobe.fill = FILL_ZERO; end
      OP_SHR:  begin strobe.toLeft = 1'b0; strobe.fill = FILL_ZERO; end
      OP_SAR:  begin strobe.toLeft = 1'b0; strobe.fill = FILL_SIGN; end
      OP_ROTL: begin strobe.toLeft = 1'b1; strobe.fill = FILL_WRAP; end
      OP_ROTR: begin strobe.toLeft = 1'b0; strobe.fill = FILL_WRAP; end
      OP_RCL:  begin strobe.toLeft = 1'b1; strobe.fill = FILL_RING; end
      OP_RCR:  begin strobe.toLeft = 1'b0; strobe.fill = FILL_RING; end
      default: strobe.bypass = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/sru_stage.sv
module sru_stage
  import sru_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SH    = 1
) (
  input  logic             enable,
  input  logic             toLeft,
  input  srFill_e          fill,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             carryOut
);

  logic [WIDTH:0] ring;
  logic [WIDTH:0] rot;

  always_comb begin
    ring     = {carryIn, dataIn};
    rot      = '0;
    dataOut  = dataIn;
    carryOut = carryIn;
    if (enable) begin
      if (toLeft) begin
        carryOut = dataIn[WIDTH-SH];
        case (fill)
          FILL_WRAP: dataOut = {dataIn[WIDTH-SH-1:0], dataIn[WIDTH-1:WIDTH-SH]};
          FILL_RING: begin
            rot      = {ring[WIDTH-SH:0], ring[WIDTH:WIDTH-SH+1]};
            dataOut  = rot[WIDTH-1:0];
            carryOut = rot[WIDTH];
          end
          default:   dataOut = {dataIn[WIDTH-SH-1:0], {SH{1'b0}}};
        endcase
      end else begin
        carryOut = dataIn[SH-1];
        case (fill)
          FILL_SIGN: dataOut = {{SH{dataIn[WIDTH-1]}}, dataIn[WIDTH-1:SH]};
          FILL_WRAP: dataOut = {dataIn[SH-1:0], dataIn[WIDTH-1:SH]};
          FILL_RING: begin
            rot      = {ring[SH-1:0], ring[WIDTH:SH]};
            dataOut  = rot[WIDTH-1:0];
            carryOut = rot[WIDTH];
          end
          default:   dataOut = {{SH{1'b0}}, dataIn[WIDTH-1:SH]};
        endcase
      end
    end
  end

endmodule

// File: rtl/sru_datapath.sv
module sru_datapath
  import sru_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  srStrobe_t        strobe,
  input  logic [CW-1:0]    count,
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroFlag,
  output logic             negFlag
);

  logic [WIDTH-1:0] stData  [CW+1];
  logic             stCarry [CW+1];

  assign stData[0]  = operand;
  assign stCarry[0] = carryIn;

  // Stage k moves by 2**k; the stages compose into one exact n-step move
  for (genvar k = 0; k < CW; k++) begin : g_stage
    sru_stage #(.WIDTH(WIDTH), .SH(1 << k)) u_stage (
      .enable  (count[k] && !strobe.bypass),
      .toLeft  (strobe.toLeft),
      .fill    (strobe.fill),
      .dataIn  (stData[k]),
      .carryIn (stCarry[k]),
      .dataOut (stData[k+1]),
      .carryOut(stCarry[k+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      carryOut <= 1'b0;
      zeroFlag <= 1'b0;
      negFlag  <= 1'b0;
    end else if (strobe.load) begin
      result   <= stData[CW];
      carryOut <= stCarry[CW];
      zeroFlag <= (stData[CW] == '0);
      negFlag  <= stData[CW][WIDTH-1];
    end
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int  WIDTH = 32,
  localparam int CW    = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       opSel,
  input  logic [CW-1:0]    count,
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroFlag,
  output logic             negFlag
);

  srStrobe_t strobe;

  sru_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opSel   (opSel),
    .strobe  (strobe),
    .outValid(outValid)
  );

  sru_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .count   (count),
    .operand (operand),
    .carryIn (carryIn),
    .result  (result),
    .carryOut(carryOut),
    .zeroFlag(zeroFlag),
    .negFlag (negFlag)
  );

endmodule

// File: rtl/shift_rotate_unit_checker.sv
module shift_rotate_unit_checker #(
  parameter int  WIDTH = 32,
  localparam int CW    = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [2:0]       opSel,
  input logic [CW-1:0]    count,
  input logic [WIDTH-1:0] operand,
  input logic             carryIn,
  input logic             outValid,
  input logic [WIDTH-1:0] result,
  input logic             carryOut
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(carryOut)));

  p_shl_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd0 && count == 1) |=>
      (result == {$past(operand[WIDTH-2:0]), 1'b0} && carryOut == $past(operand[WIDTH-1])));

  p_sar_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd2) |=> (result[WIDTH-1] == $past(operand[WIDTH-1])));

  p_rotl_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd3) |=> ($countones(result) == $countones($past(operand))));

  p_rotr_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd4 && count != 0) |=> (carryOut == result[WIDTH-1]));

  p_ring_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opSel == 3'd5 || opSel == 3'd6)) |=>
      ($countones({carryOut, result}) == $countones({$past(carryIn), $past(operand)})));

  p_zero_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && count == 0) |=>
      (result == $past(operand) && carryOut == $past(carryIn)));

  p_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd7) |=>
      (result == $past(operand) && carryOut == $past(carryIn)));

endmodule

bind shift_rotate_unit shift_rotate_unit_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opSel   (opSel),
  .count   (count),
  .operand (operand),
  .carryIn (carryIn),
  .outValid(outValid),
  .result  (result),
  .carryOut(carryOut)
);

// File: tb/shift_rotate_unit_tb.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [2:0]    opSel = '0;
  logic [4:0]    count = '0;
  logic [W-1:0]  operand = '0;
  logic          carryIn = 1'b0;
  logic          outValid;
  logic [W-1:0]  result;
  logic          carryOut;
  logic          zeroFlag;
  logic          negFlag;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  shift_rotate_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .count(count),
    .operand(operand), .carryIn(carryIn), .outValid(outValid), .result(result),
    .carryOut(carryOut), .zeroFlag(zeroFlag), .negFlag(negFlag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: n single-bit steps, one at a time
  task automatic refModel(input int op, input logic [W-1:0] x, input int n, input logic c,
                          output logic [W-1:0] r, output logic co);
    r = x; co = c;
    if (op == 7) return;
    for (int i = 0; i < n; i++) begin
      logic top, bot;
      top = r[W-1]; bot = r[0];
      case (op)
        0: begin co = top; r = {r[W-2:0], 1'b0}; end
        1: begin co = bot; r = {1'b0, r[W-1:1]}; end
        2: begin co = bot; r = {r[W-1], r[W-1:1]}; end
        3: begin co = top; r = {r[W-2:0], top}; end
        4: begin co = bot; r = {bot, r[W-1:1]}; end
        5: begin r = {r[W-2:0], co}; co = top; end
        default: begin r = {co, r[W-1:1]}; co = bot; end
      endcase
    end
  endtask

  function automatic string reqOf(input int op, input int n);
    if (n == 0) return "R9";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R10";
    endcase
  endfunction

  logic [W-1:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                             32'h7FFF_FFFE, 32'hA5C3_1E69, 32'h1234_5678};

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R12: reset values
    @(negedge clk); @(negedge clk);
    check("R12", {59'd0, outValid, carryOut, zeroFlag, negFlag}, 64'd0);
    check("R12", {32'd0, result}, 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 8; op++)
      for (int n = 0; n < 32; n++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++) begin
            logic [W-1:0] er; logic ec;
            inValid = 1'b1; opSel = 3'(op); count = 5'(n);
            operand = pats[p]; carryIn = c[0];
            refModel(op, pats[p], n, c[0], er, ec);
            @(negedge clk);
            check(reqOf(op, n), {31'd0, result, carryOut}, {31'd0, er, ec});
            check("R1", {63'd0, outValid}, 64'd1);
            check("R11", {62'd0, zeroFlag, negFlag}, {62'd0, er == '0, er[W-1]});
            if (op == 2) begin
              longint xs, q, pw;
              xs = longint'($signed(pats[p]));
              pw = longint'(1) << n;
              q  = xs / pw;
              if (xs < 0 && (xs % pw) != 0) q = q - 1;
              check("R4", longint'($signed(result)), q);
            end
          end

    // R1: idle cycle with new inputs leaves outputs held
    inValid = 1'b1; opSel = 3'd0; count = 5'd4; operand = 32'hF000_000F; carryIn = 1'b0;
    @(negedge clk);
    check("R1", {31'd0, result, carryOut}, {31'd0, 32'h0000_00F0, 1'b1});
    inValid = 1'b0; opSel = 3'd1; count = 5'd9; operand = 32'h1357_9BDF; carryIn = 1'b1;
    @(negedge clk);
    check("R1", {30'd0, outValid, result, carryOut}, {30'd0, 1'b0, 32'h0000_00F0, 1'b1});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule